// File: doc/BRIEF.md
# Programmable Processor Stall Inserter

This block watches a processor's external data bus and stretches execution on request. Every write to the X data space carries an 8-bit stall count in the upper byte of the data word (data bits 16 to 23). When the write strobe returns high at the end of an X-space write and that count is non-zero, the block pulls an active-low bus-request line true. The processor stops until the request is released, and the release comes after exactly the programmed number of clock cycles. A count of zero leaves the processor running.

Software uses the block to place a precise pause after any instruction that writes to the X space. At a 20 MHz stall clock each count step is 50 ns, so counts from 1 to 255 give pauses from 50 ns to 12.75 us. The stall begins only once the writing instruction is complete, because the count is sampled on the strobe's trailing edge. A `busy` output mirrors the internal stall flag.

Top module: `stall_inserter`

## Requirements
- R1: The stall length is taken from `dly_field`, which carries bits 16 to 23 of the data word. A sampled value N from 1 to 255 gives a stall of exactly N clock cycles.
- R2: A sampled field of zero starts no stall. `busy` stays 0 and `bus_req_n` stays 1.
- R3: The field is sampled only on a trailing (low-to-high) transition of the active-low `wr_strobe_n`, and only when `xy_sel` is 1 at that clock edge. The value 1 selects the X space. With `xy_sel` = 0 (Y space), no stall starts.
- R4: `busy` goes to 1 in the cycle after the first rising clock edge that sees `wr_strobe_n` high after it was low. No stall begins while the strobe is still low.
- R5: `bus_req_n` is 0 in exactly the cycles where `busy` is 1, and is 1 otherwise.
- R6: Once a stall ends, `busy` is 0 and stays 0 until another qualifying write.
- R7: A trailing strobe edge that arrives while a stall is in progress is ignored. The running stall keeps its original length, and no second stall follows it.
- R8: A synchronous active-high `rst` clears the stall within one clock edge, including in the middle of a stall. After reset, `busy` is 0 and `bus_req_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stall clock; each cycle is one count step |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe_n | input | 1 | Active-low external write strobe |
| xy_sel | input | 1 | Data-space select; 1 = X space, 0 = Y space |
| dly_field | input | 8 | Upper data byte (data bits 16 to 23) holding the stall count |
| bus_req_n | output | 1 | Active-low bus request that halts the processor |
| busy | output | 1 | High while a stall is in progress |

## Verification
Random writes mix X-space and Y-space selects with counts over the full byte range. The measured stall length therefore separates a correct count from an off-by-one counter, and shows whether the space select is honoured. Directed cases use counts 0, 1 and 255 to test the boundaries where the zero check and the counter wrap would show errors. A second strobe is injected in the middle of a stall to show whether it is ignored or instead reloads or extends the stall. A reset in the middle of a stall shows that the request is released at once. In every sampled cycle the bench also compares `bus_req_n` with `busy`, to catch a request that lags or leads the flag.

// File: rtl/stall_pkg.sv
package stall_pkg;
   localparam int unsigned FIELD_W_DEF = 8;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_STALL = 1'b1
   } stall_state_e;
endpackage

// File: rtl/stall_strobe_edge.sv
module stall_strobe_edge #(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe_raw,
   output logic trail_pulse
);
   logic asserted_now;
   logic asserted_q;

   generate
      if (ACTIVE_LOW) begin : g_low
         assign asserted_now = ~strobe_raw;
      end else begin : g_high
         assign asserted_now = strobe_raw;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) asserted_q <= 1'b0;
      else     asserted_q <= asserted_now;
   end

   // trailing edge: was asserted at previous edge, released now
   assign trail_pulse = asserted_q & ~asserted_now;
endmodule

// File: rtl/stall_qualify.sv
module stall_qualify #(
   parameter int unsigned FIELD_W = 8,
   parameter bit          X_LEVEL = 1'b1
) (
   input  logic               trail_pulse,
   input  logic               space_sel,
   input  logic [FIELD_W-1:0] field,
   output logic               start_req
);
   logic space_ok;
   logic field_nz;

   assign space_ok  = (space_sel == X_LEVEL);
   assign field_nz  = |field;
   assign start_req = trail_pulse & space_ok & field_nz;
endmodule

// File: rtl/stall_counter.sv
module stall_counter
   import stall_pkg::*;
#(
   parameter int unsigned FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start_req,
   input  logic [FIELD_W-1:0] load_val,
   output logic               stall_flag
);
   localparam logic [FIELD_W-1:0] ONE = {{(FIELD_W-1){1'b0}}, 1'b1};

   stall_state_e       state_q;
   logic [FIELD_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         remain_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_req) begin
                  state_q  <= ST_STALL;
                  remain_q <= load_val;
               end
            end
            ST_STALL: begin
               if (remain_q == ONE) begin
                  state_q  <= ST_IDLE;
                  remain_q <= '0;
               end else begin
                  remain_q <= remain_q - ONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign stall_flag = (state_q == ST_STALL);
endmodule

// File: rtl/stall_inserter.sv
module stall_inserter #(
   parameter int unsigned FIELD_W      = stall_pkg::FIELD_W_DEF,
   parameter bit          STROBE_LOW   = 1'b1,
   parameter bit          X_LEVEL      = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_strobe_n,
   input  logic               xy_sel,
   input  logic [FIELD_W-1:0] dly_field,
   output logic               bus_req_n,
   output logic               busy
);
   generate
      if (FIELD_W < 2 || FIELD_W > 16) begin : g_bad_width
         $error("stall_inserter: FIELD_W must be within 2..16");
      end
   endgenerate

   logic trail_pulse;
   logic start_req;
   logic stall_flag;

   stall_strobe_edge #(.ACTIVE_LOW(STROBE_LOW)) u_edge (
      .clk        (clk),
      .rst        (rst),
      .strobe_raw (wr_strobe_n),
      .trail_pulse(trail_pulse)
   );

   stall_qualify #(.FIELD_W(FIELD_W), .X_LEVEL(X_LEVEL)) u_qual (
      .trail_pulse(trail_pulse),
      .space_sel  (xy_sel),
      .field      (dly_field),
      .start_req  (start_req)
   );

   stall_counter #(.FIELD_W(FIELD_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .start_req (start_req),
      .load_val  (dly_field),
      .stall_flag(stall_flag)
   );

   assign busy      = stall_flag;
   assign bus_req_n = ~stall_flag;
endmodule

// File: rtl/stall_inserter_chk.sv
module stall_inserter_chk #(
   parameter int unsigned FIELD_W = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               wr_strobe_n,
   input logic               xy_sel,
   input logic [FIELD_W-1:0] dly_field,
   input logic               bus_req_n,
   input logic               busy
);
   logic               strb_q;
   logic               busy_q;
   logic [FIELD_W-1:0] fld_q;
   logic [FIELD_W-1:0] exp_len;
   logic [FIELD_W:0]   run_len;
   logic               trail;

   always_ff @(posedge clk) begin
      if (rst) begin
         strb_q  <= 1'b1;
         busy_q  <= 1'b0;
         fld_q   <= '0;
         exp_len <= '0;
         run_len <= '0;
      end else begin
         strb_q <= wr_strobe_n;
         busy_q <= busy;
         fld_q  <= dly_field;
         if (busy && !busy_q) begin
            exp_len <= fld_q;
            run_len <= 1;
         end else if (busy) begin
            run_len <= run_len + 1'b1;
         end
      end
   end

   assign trail = wr_strobe_n & ~strb_q;

   // R2
   zero_field_chk: assert property (@(posedge clk) disable iff (rst)
      (trail && !busy && dly_field == '0) |=> !busy);

   // R3
   y_space_chk: assert property (@(posedge clk) disable iff (rst)
      (trail && !busy && !xy_sel) |=> !busy);

   // R4
   start_chk: assert property (@(posedge clk) disable iff (rst)
      (trail && !busy && xy_sel && dly_field != '0) |=> busy);

   // R5
   req_match_chk: assert property (@(posedge clk) disable iff (rst)
      bus_req_n != busy);

   // R1
   stall_len_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !busy) |-> (run_len == {1'b0, exp_len}));

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!busy && bus_req_n));
endmodule

bind stall_inserter stall_inserter_chk #(.FIELD_W(FIELD_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_strobe_n(wr_strobe_n),
   .xy_sel     (xy_sel),
   .dly_field  (dly_field),
   .bus_req_n  (bus_req_n),
   .busy       (busy)
);

// File: tb/stall_inserter_test.sv
module stall_inserter_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_strobe_n = 1'b1;
   logic       xy_sel = 1'b1;
   logic [7:0] dly_field = '0;
   logic       bus_req_n;
   logic       busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   stall_inserter uut (
      .clk(clk), .rst(rst), .wr_strobe_n(wr_strobe_n), .xy_sel(xy_sel),
      .dly_field(dly_field), .bus_req_n(bus_req_n), .busy(busy)
   );

   always #2.5 clk = ~clk;

   function automatic int exp_stall(input logic [7:0] f, input logic xs);
      if (!xs) return 0;
      return int'(f);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // issue a write; optionally inject a second strobe after inj_at stall cycles
   task automatic do_write(input logic [7:0] f, input logic xs,
                           input int inj_at, input logic [7:0] inj_f,
                           output int len);
      int  mism = 0;
      @(negedge clk);
      dly_field = f; xy_sel = xs; wr_strobe_n = 1'b0;
      @(negedge clk);
      check("R4 no stall while strobe low", int'(busy), 0);
      @(negedge clk);
      wr_strobe_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      len = 0;
      while (busy && len < 400) begin
         if (bus_req_n == busy) mism++;
         len++;
         if (inj_at > 0 && len == inj_at) begin
            dly_field = inj_f; wr_strobe_n = 1'b0;
         end
         if (inj_at > 0 && len == inj_at + 1) wr_strobe_n = 1'b1;
         @(negedge clk);
      end
      wr_strobe_n = 1'b1;
      if (bus_req_n == busy) mism++;
      check("R5 bus_req_n tracks busy", mism, 0);
   endtask

   task automatic idle_check(input string req, input int cyc);
      int seen = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (busy || !bus_req_n) seen++;
      end
      check(req, seen, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int len;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8 reset state
      check("R8 busy after reset", int'(busy), 0);
      check("R8 bus_req_n after reset", int'(bus_req_n), 1);

      // R2 zero field
      do_write(8'd0, 1'b1, 0, 8'd0, len);
      check("R2 zero field stall", len, 0);
      idle_check("R2 request stays idle", 4);

      // R3 Y space ignored
      do_write(8'd9, 1'b0, 0, 8'd0, len);
      check("R3 Y-space stall", len, 0);
      idle_check("R3 request stays idle", 4);

      // R1 boundaries
      do_write(8'd1, 1'b1, 0, 8'd0, len);
      check("R1 count 1", len, 1);
      do_write(8'd255, 1'b1, 0, 8'd0, len);
      check("R1 count 255", len, 255);
      idle_check("R6 idle after stall", 5);

      // R7 strobe during stall ignored
      do_write(8'd20, 1'b1, 3, 8'd5, len);
      check("R7 stall length kept", len, 20);
      idle_check("R7 no follow-up stall", 8);

      // R8 reset mid-stall
      @(negedge clk);
      dly_field = 8'd50; xy_sel = 1'b1; wr_strobe_n = 1'b0;
      @(negedge clk);
      wr_strobe_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R8 stall running before reset", int'(busy), 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R8 busy cleared by reset", int'(busy), 0);
      check("R8 bus_req_n released by reset", int'(bus_req_n), 1);
      idle_check("R8 stays idle after reset", 4);

      // R1 R3 random
      for (int t = 0; t < 40; t++) begin
         logic [7:0] f;
         logic       xs;
         f  = 8'($urandom % 256);
         xs = ($urandom % 4) != 0;
         do_write(f, xs, 0, 8'd0, len);
         check("R1 R3 random stall length", len, exp_stall(f, xs));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule